// File: doc/BRIEF.md
# Differential QPSK Baseband Modulator

This block turns a serial bit stream into a differentially encoded four-phase symbol stream. Bits arrive one at a time with a valid strobe. They are collected in pairs, which halves the rate into two parallel streams. Each completed pair is a dibit. The dibit tells how many quarter turns a two-bit phase state moves forward from the previous symbol, so only the change between symbols carries information. A receiver therefore needs no absolute phase reference.

The phase state becomes a pair of sign bits, one for the in-phase arm and one for the quadrature arm. Each sign bit means plus or minus full scale. The block also drives two logic-level carrier outputs. Each one is a square wave from a free-running divider, XORed with its arm's sign bit. A sign of 1 flips that carrier by half a period, and a sign of 0 lets it through unchanged. Pulse shaping, analog levels, mixing and anything on the receive side belong to other blocks.

Top module: `dqpsk_mod`

## Requirements
- R1: A bit is accepted only on a cycle where `bit_vld_i` is 1, and `bit_i` is ignored on all other cycles. The first bit accepted after reset, or after a completed pair, is the dibit MSB. The next accepted bit is the LSB, and `sym_dibit_o` shows {MSB, LSB}.
- R2: `sym_stb_o` is 1 for exactly one clock, in the cycle after the edge that accepts the second bit of a pair, and `sym_dibit_o` is valid in that cycle. It is never 1 on two cycles in a row.
- R3: Dibit 00 leaves the phase state unchanged.
- R4: Dibit 01 advances the phase state by one quarter turn (+90 degrees), modulo 4.
- R5: Dibit 10 advances the phase state by two quarter turns (180 degrees).
- R6: Dibit 11 moves the phase state back by one quarter turn (-90 degrees), which equals three steps forward modulo 4.
- R7: The phase state changes only at the edge that ends a strobe cycle, so new sign bits appear one cycle after `sym_stb_o`. On every other cycle the sign bits hold their value.
- R8: Phase states 0, 1, 2 and 3 give (`i_sign_o`, `q_sign_o`) = (0,0), (1,0), (1,1) and (0,1), where 1 means negative.
- R9: Both carriers come from a 2-bit counter that reset sets to 0 and that then counts up once per clock. The in-phase square carrier follows the pattern 0,0,1,1 at counter values 0..3. The quadrature carrier equals the in-phase carrier of the previous clock, so it lags by a quarter of the four-clock period.
- R10: `i_carrier_o` is the in-phase carrier XOR `i_sign_o`, and `q_carrier_o` is the quadrature carrier XOR `q_sign_o`.
- R11: A synchronous reset (`rst` = 1) clears the phase state, the carrier counter and the pairing state. A bit accepted before reset without its partner is discarded, and the next accepted bit is an MSB again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_i | input | 1 | Serial data bit |
| bit_vld_i | input | 1 | Marks `bit_i` as valid this cycle |
| sym_stb_o | output | 1 | One-cycle pulse when a dibit is complete |
| sym_dibit_o | output | 2 | Completed dibit {MSB, LSB} |
| i_sign_o | output | 1 | In-phase sign bit (1 = negative) |
| q_sign_o | output | 1 | Quadrature sign bit (1 = negative) |
| i_carrier_o | output | 1 | In-phase square carrier XOR in-phase sign |
| q_carrier_o | output | 1 | Quadrature square carrier XOR quadrature sign |

## Verification
Assertions check the following on every cycle:
- the strobe is a single-cycle pulse;
- the phase holds between strobes;
- dibit 00 leaves the signs untouched and dibit 10 flips both signs;
- reset clears the pairing and phase registers;
- the quadrature carrier repeats the in-phase carrier one clock later.

Other behaviour can only be shown by the bench's scenarios:
- the exact modulo-4 arithmetic for 01 and 11;
- the MSB-first pairing order across gaps in the valid strobe;
- a half-received pair being dropped by reset;
- the carrier phase measured from reset release.

To cover these, the scoreboard checks every symbol's dibit and the sign bits that follow it against a phase model of its own, and it checks both carrier outputs on every cycle.

// File: rtl/dqpsk_pkg.sv
package dqpsk_pkg;
    localparam int SYM_W = 2;   // bits per symbol
    localparam int PH_W  = 2;   // quarter-turn phase counter
    localparam int CAR_W = 2;   // carrier divider width, period 2**CAR_W

    typedef logic [SYM_W-1:0] dibit_t;
    typedef logic [PH_W-1:0]  phase_t;
    typedef logic [CAR_W-1:0] car_cnt_t;

    typedef struct packed {
        logic   half;
        logic   msb;
        logic   stb;
        dibit_t dibit;
    } pair_state_t;
endpackage

// File: rtl/dqpsk_bit_pairer.sv
module dqpsk_bit_pairer
    import dqpsk_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   bit_i,
    input  logic   bit_vld_i,
    output logic   stb_o,
    output dibit_t dibit_o
);
    pair_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        if (bit_vld_i) begin
            if (!st_q.half) begin
                st_d.half = 1'b1;
                st_d.msb  = bit_i;
            end else begin
                st_d.half  = 1'b0;
                st_d.stb   = 1'b1;
                st_d.dibit = {st_q.msb, bit_i};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign stb_o   = st_q.stb;
    assign dibit_o = st_q.dibit;

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
        st_q.stb |=> !st_q.stb); // R2
    AST_PAIR_CLEARED: assert property (@(posedge clk)
        rst |=> (!st_q.stb && !st_q.half)); // R11
endmodule

// File: rtl/dqpsk_phase_map.sv
module dqpsk_phase_map
    import dqpsk_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   stb_i,
    input  dibit_t dibit_i,
    output logic   i_sign_o,
    output logic   q_sign_o
);
    phase_t ph_d, ph_q;

    // Natural-binary increment: the dibit value is the number of quarter turns.
    always_comb begin
        ph_d = ph_q;
        if (stb_i) ph_d = ph_q + phase_t'(dibit_i);
    end

    always_ff @(posedge clk) begin
        if (rst) ph_q <= '0;
        else     ph_q <= ph_d;
    end

    // 0:(0,0) 1:(1,0) 2:(1,1) 3:(0,1)
    assign i_sign_o = ph_q[1] ^ ph_q[0];
    assign q_sign_o = ph_q[1];

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !stb_i |=> $stable(ph_q)); // R7
    AST_ZERO_STEP: assert property (@(posedge clk) disable iff (rst)
        (stb_i && dibit_i == 2'b00) |=> ($stable(i_sign_o) && $stable(q_sign_o))); // R3
    AST_HALF_TURN: assert property (@(posedge clk) disable iff (rst)
        (stb_i && dibit_i == 2'b10) |=>
        (i_sign_o != $past(i_sign_o) && q_sign_o != $past(q_sign_o))); // R5
    AST_PHASE_CLEARED: assert property (@(posedge clk)
        rst |=> (!i_sign_o && !q_sign_o)); // R11
endmodule

// File: rtl/dqpsk_carrier_gen.sv
module dqpsk_carrier_gen
    import dqpsk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output logic i_car_o,
    output logic q_car_o
);
    car_cnt_t cnt_d, cnt_q;

    always_comb cnt_d = cnt_q + car_cnt_t'(1);

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    // In-phase: high for the upper half of the count.
    // Quadrature: the in-phase value of the previous count.
    assign i_car_o = cnt_q[CAR_W-1];
    assign q_car_o = ~(cnt_q[CAR_W-1] ^ cnt_q[CAR_W-2]);

    // Checker state: previous in-phase value, armed once reset is released.
    logic prev_i_q, armed_q;
    always_ff @(posedge clk) begin
        prev_i_q <= i_car_o;
        armed_q  <= !rst;
    end

    AST_Q_LAGS_I: assert property (@(posedge clk) disable iff (rst)
        armed_q |-> (q_car_o == prev_i_q)); // R9
endmodule

// File: rtl/dqpsk_mod.sv
module dqpsk_mod
    import dqpsk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_i,
    input  logic       bit_vld_i,
    output logic       sym_stb_o,
    output logic [1:0] sym_dibit_o,
    output logic       i_sign_o,
    output logic       q_sign_o,
    output logic       i_carrier_o,
    output logic       q_carrier_o
);
    logic   stb;
    dibit_t dibit;
    logic   i_car, q_car;

    dqpsk_bit_pairer u_pair (
        .clk(clk), .rst(rst), .bit_i(bit_i), .bit_vld_i(bit_vld_i),
        .stb_o(stb), .dibit_o(dibit)
    );

    dqpsk_phase_map u_phase (
        .clk(clk), .rst(rst), .stb_i(stb), .dibit_i(dibit),
        .i_sign_o(i_sign_o), .q_sign_o(q_sign_o)
    );

    dqpsk_carrier_gen u_car (
        .clk(clk), .rst(rst), .i_car_o(i_car), .q_car_o(q_car)
    );

    assign sym_stb_o   = stb;
    assign sym_dibit_o = dibit;
    assign i_carrier_o = i_car ^ i_sign_o;
    assign q_carrier_o = q_car ^ q_sign_o;
endmodule

// File: tb/dqpsk_mod_tb.sv
`timescale 1ns/1ps
module dqpsk_mod_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_i = 1'b0;
    logic bit_vld_i = 1'b0;
    logic sym_stb_o, i_sign_o, q_sign_o, i_carrier_o, q_carrier_o;
    logic [1:0] sym_dibit_o;

    always #2.5 clk = ~clk;

    dqpsk_mod u_dut (
        .clk(clk), .rst(rst), .bit_i(bit_i), .bit_vld_i(bit_vld_i),
        .sym_stb_o(sym_stb_o), .sym_dibit_o(sym_dibit_o),
        .i_sign_o(i_sign_o), .q_sign_o(q_sign_o),
        .i_carrier_o(i_carrier_o), .q_carrier_o(q_carrier_o)
    );

    int checks = 0;
    int fails  = 0;

    typedef struct packed {
        logic [1:0] dibit;
        logic       isg;
        logic       qsg;
    } exp_t;
    exp_t exp_q[$];

    int unsigned ph_model = 0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    // Bench reference for the carrier counter: 0 during reset, then +1 per clock.
    logic [1:0] ref_cnt = 2'd0;
    always @(posedge clk) ref_cnt <= rst ? 2'd0 : ref_cnt + 2'd1;

    // Monitor
    logic pend = 1'b0;
    exp_t pend_e;
    logic cur_i = 1'b0, cur_q = 1'b0;
    always @(negedge clk) begin
        if (rst) begin
            pend  = 1'b0;
            cur_i = 1'b0;
            cur_q = 1'b0;
        end else begin
            logic ic, qc;
            if (pend) begin
                cur_i = pend_e.isg;
                cur_q = pend_e.qsg;
                pend  = 1'b0;
            end
            check(i_sign_o == cur_i, "R8 i_sign", i_sign_o, cur_i);
            check(q_sign_o == cur_q, "R8 q_sign", q_sign_o, cur_q);
            if (sym_stb_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1 unexpected strobe", 1, 0);
                end else begin
                    pend_e = exp_q.pop_front();
                    check(sym_dibit_o == pend_e.dibit, "R1 dibit", sym_dibit_o, pend_e.dibit);
                    pend = 1'b1;
                end
            end
            // R9/R10: in-phase 0,0,1,1; quadrature one clock behind, i.e. 1,0,0,1.
            ic = ref_cnt[1];
            qc = (ref_cnt == 2'd0) || (ref_cnt == 2'd3);
            check(i_carrier_o == (ic ^ i_sign_o), "R10 i_carrier", i_carrier_o, ic ^ i_sign_o);
            check(q_carrier_o == (qc ^ q_sign_o), "R9 q_carrier", q_carrier_o, qc ^ q_sign_o);
        end
    end

    task automatic push_symbol(input logic [1:0] d);
        exp_t e;
        ph_model = (ph_model + d) % 4;          // R3..R6 modulo-4 step
        e.dibit  = d;
        e.isg    = (ph_model == 1) || (ph_model == 2);
        e.qsg    = (ph_model >= 2);
        exp_q.push_back(e);
    endtask

    // Sends one dibit, starting at a negedge; gap = idle cycles between the two bits.
    task automatic send_dibit(input logic [1:0] d, input int gap);
        bit_i = d[1]; bit_vld_i = 1'b1;
        @(negedge clk);
        for (int g = 0; g < gap; g++) begin
            bit_vld_i = 1'b0; bit_i = ~bit_i;   // R1: ignored bits
            @(negedge clk);
        end
        bit_i = d[0]; bit_vld_i = 1'b1;
        push_symbol(d);
        @(negedge clk);
        bit_vld_i = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; bit_vld_i = 1'b0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0; ph_model = 0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(sym_stb_o == 1'b0, "R11 strobe after reset", sym_stb_o, 0);
        check({i_sign_o, q_sign_o} == 2'b00, "R11 signs after reset", {i_sign_o, q_sign_o}, 0);

        // R4 steps of +90 through all four states
        for (int k = 0; k < 5; k++) begin send_dibit(2'b01, 0); idle(2); end
        // R6 steps of -90
        for (int k = 0; k < 5; k++) begin send_dibit(2'b11, 0); idle(1); end
        // R5 half turns, R3 no change
        send_dibit(2'b10, 0); idle(2);
        send_dibit(2'b00, 0); idle(2);
        send_dibit(2'b10, 1); idle(2);
        send_dibit(2'b00, 3); idle(2);
        // R1 pairing with gaps and ignored toggles
        send_dibit(2'b01, 2); idle(1);
        send_dibit(2'b10, 4); idle(1);
        // R2 bits back to back: a stream of many dibits with no gaps
        for (int k = 0; k < 8; k++) begin
            logic [1:0] d;
            d = 2'(k * 3 + 1);
            bit_i = d[1]; bit_vld_i = 1'b1; @(negedge clk);
            bit_i = d[0]; push_symbol(d); @(negedge clk);
        end
        bit_vld_i = 1'b0;
        idle(3);
        // R1: valid low, toggling data must give no strobe (unexpected strobe fails)
        for (int k = 0; k < 6; k++) begin bit_i = ~bit_i; @(negedge clk); end
        idle(2);

        // R11: half dibit then reset; next bit is MSB again
        send_dibit(2'b11, 0); idle(1);
        bit_i = 1'b1; bit_vld_i = 1'b1; @(negedge clk); bit_vld_i = 1'b0;
        idle(1);
        do_reset();
        @(negedge clk);
        check({i_sign_o, q_sign_o} == 2'b00, "R11 phase cleared", {i_sign_o, q_sign_o}, 0);
        send_dibit(2'b01, 0); idle(3);
        send_dibit(2'b10, 0); idle(3);

        check(exp_q.size() == 0, "R2 all symbols strobed", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule